// File: doc/BRIEF.md
# I2C Register Target with Shared Auto-Increment Pointer

This block is an I2C target that lets an external bus controller read and write a bank of 21 byte-wide control registers (addresses 00h to 14h). The SCL and SDA lines are first brought into the system clock domain. SDA is driven only through an open-drain enable: a high on the enable pulls the line low. The block recognises START, repeated START and STOP, and it answers one fixed 7-bit device address.

All transfers use a single 6-bit register pointer, which reads and writes share and which keeps its value between transactions. In a write frame, the first byte after the address byte sets the pointer. Every later byte is stored at the pointer, and the pointer then steps forward. A read frame begins at the current pointer. To read from a chosen address, the controller sends a write frame that holds only the register address, then a repeated START and a read address byte. After address 14h the pointer wraps to 00h in either direction. The register contents are also offered to the surrounding logic on a combinational parallel read port.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset every register and the pointer are 00h, and the SDA enable is low.
- R2: The target acknowledges an address byte only when its upper seven bits equal DEV_ADDR (default 12h). Bit 0 of that byte selects the direction: 1 means read, 0 means write.
- R3: When the address does not match, the target gives no ACK. It then ignores every byte until the next START or STOP, so no register and not the pointer change.
- R4: In a write frame the target acknowledges every byte. The first data byte loads the pointer. Each later byte is written at the pointer, and the pointer then increments.
- R5: A pointer at 14h that increments goes to 00h. Register 14h is transferred before the wrap, both in writes and in reads.
- R6: A read frame that follows a STOP starts at the pointer left by the previous access, whether that access was a read or a write.
- R7: A write frame that carries only a register address, followed by a repeated START and a read address byte, returns data starting at that register address.
- R8: When the controller ACKs a read byte, the next register is sent. After a NACK the target releases SDA and sends nothing more until a START.
- R9: The SDA enable changes only while SCL is low. Incoming SDA is sampled on SCL rising edges.
- R10: rd_data_o shows the register selected by rd_addr_i with no clock delay. It reads 00h for addresses above 14h.
- R11: The pointer may be loaded above 14h. Writes at such a pointer are discarded, reads there return 00h, and the next increment returns the pointer to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| rd_addr_i | input | 6 | Parallel read port address |
| rd_data_o | output | 8 | Register contents at rd_addr_i |

## Verification
The assertions assume that SDA changes only while SCL is low, except at START and STOP. They also assume that every SCL high phase and low phase lasts many system clocks longer than the synchroniser delay, so the target's enable settles within the same low phase. The bench's controller model keeps to both assumptions: it changes SDA a quarter bit after it drops SCL, and it holds each SCL phase for twenty system clocks. A monitor flags any change of the SDA enable while SCL is high.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TACK,
    ST_WRB,
    ST_RDB,
    ST_RACK,
    ST_SKIP
  } tgt_state_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
  import i2c_reg_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  logic scl_s, sda_s;
  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_comb begin
    ev_o.scl      = scl_s;
    ev_o.sda      = sda_s;
    ev_o.scl_rise = scl_s & ~scl_d;
    ev_o.scl_fall = ~scl_s & scl_d;
    ev_o.start    = scl_s & scl_d & sda_d & ~sda_s;
    ev_o.stop     = scl_s & scl_d & ~sda_d & sda_s;
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_reg_pkg::*;
#(
  parameter int NUM_REGS = 21,
  parameter int PTR_W    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_load_i,
  input  logic [PTR_W-1:0]  ptr_val_i,
  input  logic              ptr_inc_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  logic [PTR_W-1:0]  ptr_q;
  logic [BYTE_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (ptr_load_i) ptr_q <= ptr_val_i;
    else if (ptr_inc_i)  ptr_q <= (ptr_q >= LAST) ? '0 : ptr_q + PTR_W'(1);
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= '0;
      else if (wr_en_i && ptr_q == PTR_W'(g)) q <= wr_data_i;
    end
    assign regs[g] = q;
  end

  always_comb begin
    tx_data_o = '0;
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr_q == PTR_W'(i))     tx_data_o = regs[i];
      if (rd_addr_i == PTR_W'(i)) rd_data_o = regs[i];
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h12,
  parameter int         PTR_W    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_ev_t           ev_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_oe_o,
  output logic              ptr_load_o,
  output logic [PTR_W-1:0]  ptr_val_o,
  output logic              ptr_inc_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  tgt_state_e        state_q;
  logic [2:0]        cnt_q;
  logic              full_q, rw_q, first_q, oe_q, mack_q;
  logic [BYTE_W-1:0] sh_q;

  logic byte_evt, load_tx, wr_byte;
  assign byte_evt = ev_i.scl_fall & full_q;
  assign wr_byte  = (state_q == ST_WRB) & byte_evt;
  assign load_tx  = ev_i.scl_fall & ((state_q == ST_TACK & rw_q) |
                                     (state_q == ST_RACK & mack_q));

  assign wr_en_o    = wr_byte & ~first_q;
  assign ptr_load_o = wr_byte & first_q;
  assign ptr_val_o  = sh_q[PTR_W-1:0];
  assign wr_data_o  = sh_q;
  assign ptr_inc_o  = load_tx | wr_en_o;
  assign sda_oe_o   = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      rw_q    <= 1'b0;
      first_q <= 1'b1;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
      sh_q    <= '0;
    end else if (ev_i.start) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      first_q <= 1'b1;
      oe_q    <= 1'b0;
    end else if (ev_i.stop) begin
      state_q <= ST_IDLE;
      full_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WRB: begin
          if (ev_i.scl_rise) begin
            sh_q  <= {sh_q[BYTE_W-2:0], ev_i.sda};
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) full_q <= 1'b1;
          end
          if (byte_evt) begin
            full_q <= 1'b0;
            cnt_q  <= '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                oe_q    <= 1'b1;
                rw_q    <= sh_q[0];
                state_q <= ST_TACK;
              end else begin
                state_q <= ST_SKIP;
              end
            end else begin
              oe_q    <= 1'b1;
              first_q <= 1'b0;
              state_q <= ST_TACK;
            end
          end
        end
        ST_TACK: begin
          if (ev_i.scl_fall) begin
            if (rw_q) begin
              sh_q    <= tx_data_i;
              oe_q    <= ~tx_data_i[7];
              cnt_q   <= '0;
              state_q <= ST_RDB;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WRB;
            end
          end
        end
        ST_RDB: begin
          if (ev_i.scl_fall) begin
            if (cnt_q == 3'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_RACK;
            end else begin
              sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
              oe_q  <= ~sh_q[6];
              cnt_q <= cnt_q + 3'd1;
            end
          end
        end
        ST_RACK: begin
          if (ev_i.scl_rise) mack_q <= ~ev_i.sda;
          if (ev_i.scl_fall) begin
            if (mack_q) begin
              sh_q    <= tx_data_i;
              oe_q    <= ~tx_data_i[7];
              cnt_q   <= '0;
              state_q <= ST_RDB;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h12,
  parameter int         NUM_REGS    = 21,
  parameter int         PTR_W       = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  bus_ev_t           bus_ev;
  logic [PTR_W-1:0]  ptr, ptr_val;
  logic              ptr_load, ptr_inc, wr_en;
  logic [BYTE_W-1:0] wr_data, tx_data;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i, .rst_ni, .scl_i, .sda_i, .ev_o(bus_ev)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) fsm_i (
    .clk_i, .rst_ni,
    .ev_i       (bus_ev),
    .tx_data_i  (tx_data),
    .sda_oe_o,
    .ptr_load_o (ptr_load),
    .ptr_val_o  (ptr_val),
    .ptr_inc_o  (ptr_inc),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) bank_i (
    .clk_i, .rst_ni,
    .ptr_load_i (ptr_load),
    .ptr_val_i  (ptr_val),
    .ptr_inc_i  (ptr_inc),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_addr_i,
    .ptr_o      (ptr),
    .tx_data_o  (tx_data),
    .rd_data_o
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int LAST_ADDR = 20,
  parameter int PTR_W     = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s,
  input logic             sda_oe,
  input logic             start,
  input logic             stop,
  input logic             ptr_load,
  input logic             ptr_inc,
  input logic [PTR_W-1:0] ptr_val,
  input logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(LAST_ADDR);

  a_r9_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe) |-> !scl_s);

  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_inc && !ptr_load && ptr < LAST_P) |=> ptr == $past(ptr) + PTR_W'(1));

  a_r5_ptr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_inc && !ptr_load && ptr >= LAST_P) |=> ptr == '0);

  a_r7_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_load |=> ptr == $past(ptr_val));

  a_r8_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !sda_oe);

  a_r3_start_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !sda_oe);
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.LAST_ADDR(NUM_REGS - 1), .PTR_W(PTR_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (bus_ev.scl),
  .sda_oe   (sda_oe_o),
  .start    (bus_ev.start),
  .stop     (bus_ev.stop),
  .ptr_load (ptr_load),
  .ptr_inc  (ptr_inc),
  .ptr_val  (ptr_val),
  .ptr      (ptr)
);

// File: tb/i2c_reg_target_tb_top.sv
module i2c_reg_target_tb_top;
  localparam logic [6:0] DEV  = 7'h12;
  localparam int         NREG = 21;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;

  always #10 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_reg_target dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  int n_chk = 0, n_fail = 0, oe_viol = 0;
  bit done = 1'b0;
  logic [7:0] exp_regs [NREG];
  int exp_ptr = 0;

  // {reg, value}
  localparam logic [15:0] WR_TAB [8] = '{
    16'h00_5A, 16'h03_C3, 16'h07_81, 16'h0A_3C,
    16'h0F_E7, 16'h11_18, 16'h12_96, 16'h14_7E};

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (scl && sda_oe !== prev_oe) oe_viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(int p);
    return (p >= NREG - 1) ? 0 : p + 1;
  endfunction

  task automatic wq();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl) begin
      m_sda = 1'b1; wq(); scl = 1'b1; wq();
    end
    m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); scl = 1'b1; wq();
    ack = ~sda_bus;
    wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_bus; wq(); scl = 1'b0; wq();
    end
    m_sda = ~mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  task automatic write_burst(input logic [5:0] addr, input int n, input logic [7:0] base, input string req);
    logic ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R2 write addr ack", ack, 1);
    send_byte({2'b00, addr}, ack); chk(ack, "R4 pointer byte ack", ack, 1);
    exp_ptr = addr;
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i), ack);
      chk(ack, req, ack, 1);
      if (exp_ptr < NREG) exp_regs[exp_ptr] = base + 8'(i);
      exp_ptr = nxt(exp_ptr);
    end
    bus_stop();
  endtask

  task automatic read_burst(input bit random, input logic [5:0] addr, input int n, input string req);
    logic ack;
    logic [7:0] b, e;
    bus_start();
    if (random) begin
      send_byte({DEV, 1'b0}, ack);
      send_byte({2'b00, addr}, ack);
      exp_ptr = addr;
      bus_start();
    end
    send_byte({DEV, 1'b1}, ack); chk(ack, "R2 read addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      e = (exp_ptr < NREG) ? exp_regs[exp_ptr] : 8'h00;
      chk(b === e, req, b, e);
      exp_ptr = nxt(exp_ptr);
    end
    chk(!sda_oe, "R8 SDA released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic port_chk(input logic [5:0] a, input string req);
    logic [7:0] e;
    rd_addr = a; #1;
    e = (a < NREG) ? exp_regs[a] : 8'h00;
    chk(rd_data === e, req, rd_data, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic ack;
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(!sda_oe, "R1 SDA released", sda_oe, 0);
    for (int i = 0; i < NREG; i++) port_chk(6'(i), "R1 reset register");
    read_burst(1'b0, 6'h0, 1, "R1 R6 pointer resets to 00h");

    // table-driven single-byte writes
    for (int v = 0; v < 8; v++) begin
      write_burst(WR_TAB[v][13:8], 1, WR_TAB[v][7:0], "R4 data ack");
      port_chk(WR_TAB[v][13:8], "R4 R10 written value on port");
    end

    // R5 write burst across wrap
    write_burst(6'h13, 5, 8'hA0, "R5 burst write ack");
    port_chk(6'h13, "R5 write 13h"); port_chk(6'h14, "R5 write 14h before wrap");
    port_chk(6'h00, "R5 write wraps to 00h"); port_chk(6'h02, "R5 write 02h");

    // R6 current read after write
    read_burst(1'b0, 6'h0, 1, "R6 current read after write");
    // R7 random read with ACK continuation
    read_burst(1'b1, 6'h0F, 4, "R7 R8 random read burst");
    // R6 current read after read
    read_burst(1'b0, 6'h0, 2, "R6 current read after read");
    // R5 read across wrap
    read_burst(1'b1, 6'h13, 3, "R5 read wrap 14h to 00h");

    // R3 address mismatch ignored
    bus_start();
    send_byte({7'h13, 1'b0}, ack); chk(!ack, "R3 no ACK on wrong address", ack, 0);
    send_byte(8'h02, ack); chk(!ack, "R3 no ACK after mismatch", ack, 0);
    send_byte(8'hEE, ack); chk(!ack, "R3 no ACK on ignored data", ack, 0);
    bus_stop();
    port_chk(6'h02, "R3 register unchanged");
    read_burst(1'b0, 6'h0, 1, "R3 R6 pointer unchanged by mismatch");
    bus_start();
    send_byte({7'h12, 1'b1} ^ 8'h80, ack); chk(!ack, "R3 no ACK on wrong read address", ack, 0);
    bus_stop();

    // R11 out-of-range pointer
    read_burst(1'b1, 6'h30, 2, "R11 read above 14h gives 00h then 00h reg");
    write_burst(6'h30, 2, 8'hC0, "R11 write ack out of range");
    port_chk(6'h00, "R11 increment from out of range lands on 00h");
    port_chk(6'h30, "R10 port above 14h reads 00h");
    port_chk(6'h3F, "R10 port top address reads 00h");

    chk(oe_viol == 0, "R9 SDA enable changed while SCL high", oe_viol, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule